// File: doc/BRIEF.md
# Two-Ratio Prescaled Feedback Divider

This block divides a fast synthesizer clock by a programmable integer N and hands one divided pulse per output period to a phase comparator. A prescaler that divides by 4 or by 5 carries the fast clock. Behind it, two slow counters steer the prescaler. A swallow count `A` (0..3) selects how many prescaler cycles at the start of each period run at the /5 ratio. A main count `M` sets how many prescaler cycles make up the period. The modulus is therefore N = 4*M + A. Any integer from 37 to 448 is reachable, and the swallow count never exceeds the main count.

A doubling control places a toggle stage behind the base divider. With doubling on, the output period becomes 2N, so every even modulus from 74 up to 896 is available. The toggle output is then a 50% duty square wave.

A setting whose modulus falls outside 37..448 raises an error flag and is never used; the divider keeps the last valid setting. New settings are read only in the first cycle of an output period, so a period in progress is never cut short.

Top module: `fbdiv_top`

## Requirements
- R1: With doubling off and a valid setting, `fb_pulse_o` is high for exactly one cycle every N = 4*M + A clock cycles, where `main_i` carries M and `swallow_i` carries A.
- R2: After reset is released, the first `fb_pulse_o` rises at exactly the N-th rising clock edge, using the setting present on the inputs in the first cycle after release.
- R3: Within each base period the prescaler runs at /5 for the first A prescaler cycles and at /4 for the remaining M-A cycles. As a result, settings with the same M and different A differ in period by exactly the difference in A.
- R4: With `double_i` = 1 the output period is 2N. `fb_pulse_o` pulses once per 2N cycles, at the edge where `fb_half_o` falls. `fb_half_o` is low for the first N cycles and high for the next N cycles of each doubled period, and it stays low while doubling is off.
- R5: `cfg_err_o` is high in the cycle after the inputs carry a setting with 4*M + A below 37 or above 448, and low in the cycle after a setting within range.
- R6: An out-of-range setting is never applied: the divider keeps the last valid setting, or N = 37 (M = 9, A = 1, doubling off) if no valid setting has been taken since reset.
- R7: Inputs are taken only in the first cycle of an output period, which is the cycle after a pulse edge or the first cycle after reset. A change made in any other cycle first affects the following period.
- R8: With doubling on, only the first cycle of each doubled period accepts a new setting. A change made in the first half is deferred past the midpoint, so no pulse appears at N.
- R9: While reset is asserted, `fb_pulse_o`, `fb_half_o` and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| swallow_i | input | 2 | Swallow count A: number of /5 prescaler cycles per base period |
| main_i | input | 7 | Main count M: prescaler cycles per base period |
| double_i | input | 1 | Doubles the output period when set |
| fb_pulse_o | output | 1 | One-cycle pulse per output period |
| fb_half_o | output | 1 | 50% duty square wave in doubled mode, low otherwise |
| cfg_err_o | output | 1 | Registered flag for an out-of-range setting on the inputs |

## Verification
Two events can coincide in one cycle: a period boundary, when the counters reload, and a change on the setting inputs. The bench changes the inputs in the very first cycle of a period, and again one cycle later. It checks that the first case takes effect at once and the second waits a full period, with the pulse edge counted from reset release. The same race is provoked in doubled mode at the midpoint boundary, where acceptance must be refused. An out-of-range value arriving near a boundary must raise the flag while the held modulus keeps setting the pulse spacing.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int unsigned FB_PRE  = 4;    // low prescaler ratio; high ratio is FB_PRE+1
  localparam int unsigned FB_AW   = 2;    // swallow field width
  localparam int unsigned FB_MW   = 7;    // main field width
  localparam int unsigned FB_NMIN = 37;
  localparam int unsigned FB_NMAX = 448;
  localparam int unsigned FB_NW   = $clog2(2 * FB_NMAX + 1);
  localparam int unsigned FB_PW   = $clog2(FB_PRE + 2);

  localparam logic [FB_NW-1:0] FB_LO_N  = FB_NW'(FB_NMIN);
  localparam logic [FB_NW-1:0] FB_HI_N  = FB_NW'(FB_NMAX);
  localparam logic [FB_NW-1:0] FB_PRE_N = FB_NW'(FB_PRE);
  localparam logic [FB_AW:0]   FB_PRE_A = (FB_AW + 1)'(FB_PRE);

  typedef struct packed {
    logic             dbl;
    logic [FB_MW-1:0] m;
    logic [FB_AW-1:0] a;
  } fb_cfg_t;

  // base modulus of a main/swallow pair
  function automatic logic [FB_NW-1:0] fb_modulus(input logic [FB_MW-1:0] m,
                                                  input logic [FB_AW-1:0] a);
    logic [FB_NW-1:0] n;
    n = FB_NW'(m) * FB_PRE_N + FB_NW'(a);
    return n;
  endfunction

  // a setting is usable when the swallow fits the prescaler, does not
  // exceed the main count and the modulus lies in the supported window
  function automatic logic fb_setting_ok(input logic [FB_MW-1:0] m,
                                         input logic [FB_AW-1:0] a);
    logic [FB_NW-1:0] n;
    n = fb_modulus(m, a);
    return ({1'b0, a} < FB_PRE_A) && (FB_MW'(a) <= m) &&
           (n >= FB_LO_N) && (n <= FB_HI_N);
  endfunction
endpackage

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg
  import fbdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FB_AW-1:0] a_i,
  input  logic [FB_MW-1:0] m_i,
  input  logic             dbl_i,
  input  logic             accept_i,
  output fb_cfg_t          cfg_o,
  output logic             err_o
);
  localparam fb_cfg_t DEF_CFG = '{dbl: 1'b0,
                                  m:   FB_MW'(FB_NMIN / FB_PRE),
                                  a:   FB_AW'(FB_NMIN % FB_PRE)};

  fb_cfg_t hold_q;
  fb_cfg_t req;
  logic    in_ok;
  logic    take;
  logic    err_q;

  assign req   = '{dbl: dbl_i, m: m_i, a: a_i};
  assign in_ok = fb_setting_ok(m_i, a_i);
  assign take  = accept_i && in_ok;
  // setting in force for the current period
  assign cfg_o = take ? req : hold_q;
  assign err_o = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= DEF_CFG;
      err_q  <= 1'b0;
    end else begin
      hold_q <= cfg_o;
      err_q  <= !in_ok;
    end
  end
endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
  import fbdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wide_now_i,
  input  logic wide_next_i,
  output logic tc_o
);
  localparam logic [FB_PW-1:0] LAST_LO = FB_PW'(FB_PRE - 1);
  localparam logic [FB_PW-1:0] LAST_HI = FB_PW'(FB_PRE);
  localparam logic [FB_PW-1:0] ONE     = FB_PW'(1);

  logic [FB_PW-1:0] cnt_q;
  logic [FB_PW-1:0] cur;

  // at a period start the count is seeded in the same cycle
  assign cur  = start_i ? (wide_now_i ? LAST_HI : LAST_LO) : cnt_q;
  assign tc_o = (cur == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tc_o) begin
      cnt_q <= wide_next_i ? LAST_HI : LAST_LO;
    end else begin
      cnt_q <= cur - ONE;
    end
  end
endmodule

// File: rtl/fbdiv_counters.sv
module fbdiv_counters
  import fbdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pre_tc_i,
  input  logic [FB_AW-1:0] a_i,
  input  logic [FB_MW-1:0] m_i,
  output logic             wide_now_o,
  output logic             wide_next_o,
  output logic             base_tc_o
);
  localparam logic [FB_AW-1:0] A_ONE = FB_AW'(1);
  localparam logic [FB_MW-1:0] M_ONE = FB_MW'(1);

  logic [FB_AW-1:0] sw_q;
  logic [FB_MW-1:0] mn_q;
  logic [FB_AW-1:0] cur_sw;
  logic [FB_MW-1:0] cur_mn;

  assign cur_sw      = start_i ? a_i : sw_q;
  assign cur_mn      = start_i ? m_i : mn_q;
  assign wide_now_o  = (cur_sw != '0);
  assign wide_next_o = (cur_sw > A_ONE);
  assign base_tc_o   = pre_tc_i && (cur_mn == M_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
      mn_q <= '0;
    end else if (pre_tc_i) begin
      sw_q <= wide_now_o ? (cur_sw - A_ONE) : '0;
      mn_q <= cur_mn - M_ONE;
    end else begin
      sw_q <= cur_sw;
      mn_q <= cur_mn;
    end
  end
endmodule

// File: rtl/fbdiv_double.sv
module fbdiv_double (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tc_i,
  input  logic dbl_i,
  output logic half_o,
  output logic pulse_o
);
  logic tgl_q;
  logic pulse_q;

  assign half_o  = tgl_q;
  assign pulse_o = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (base_tc_i && dbl_i) begin
        tgl_q <= !tgl_q;
      end
      pulse_q <= base_tc_i && (!dbl_i || tgl_q);
    end
  end
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FB_AW-1:0] swallow_i,
  input  logic [FB_MW-1:0] main_i,
  input  logic             double_i,
  output logic             fb_pulse_o,
  output logic             fb_half_o,
  output logic             cfg_err_o
);
  logic    start_q;    // first cycle of a base period
  logic    accept;     // first cycle of an output period
  logic    base_tc;    // last cycle of a base period
  logic    pre_tc;     // last cycle of a prescaler cycle
  logic    wide_now;   // current prescaler cycle runs at the high ratio
  logic    wide_next;  // following prescaler cycle runs at the high ratio
  fb_cfg_t cur_cfg;

  assign accept = start_q && !fb_half_o;

  fbdiv_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_i      (swallow_i),
    .m_i      (main_i),
    .dbl_i    (double_i),
    .accept_i (accept),
    .cfg_o    (cur_cfg),
    .err_o    (cfg_err_o)
  );

  fbdiv_prescaler u_pre (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_q),
    .wide_now_i  (wide_now),
    .wide_next_i (wide_next),
    .tc_o        (pre_tc)
  );

  fbdiv_counters u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_q),
    .pre_tc_i    (pre_tc),
    .a_i         (cur_cfg.a),
    .m_i         (cur_cfg.m),
    .wide_now_o  (wide_now),
    .wide_next_o (wide_next),
    .base_tc_o   (base_tc)
  );

  fbdiv_double u_dbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tc_i (base_tc),
    .dbl_i     (cur_cfg.dbl),
    .half_o    (fb_half_o),
    .pulse_o   (fb_pulse_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
    end else begin
      start_q <= base_tc;
    end
  end
endmodule

// File: rtl/fbdiv_chk.sv
module fbdiv_chk
  import fbdiv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [FB_AW-1:0] swallow_i,
  input logic [FB_MW-1:0] main_i,
  input logic             fb_pulse_o,
  input logic             fb_half_o,
  input logic             cfg_err_o,
  input logic             start_q,
  input logic             base_tc,
  input logic             pre_tc,
  input logic             wide_now,
  input fb_cfg_t          cur_cfg
);
  localparam logic [FB_PW-1:0] LEN_LO = FB_PW'(FB_PRE);
  localparam logic [FB_PW-1:0] LEN_HI = FB_PW'(FB_PRE + 1);

  logic [FB_NW-1:0] per_len_q;
  logic [FB_PW-1:0] pre_len_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_len_q <= FB_NW'(1);
      pre_len_q <= FB_PW'(1);
      seen_q    <= 1'b0;
    end else begin
      per_len_q <= base_tc ? FB_NW'(1) : per_len_q + FB_NW'(1);
      pre_len_q <= pre_tc ? FB_PW'(1) : pre_len_q + FB_PW'(1);
      seen_q    <= 1'b1;
    end
  end

  assert_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    base_tc |-> per_len_q == fb_modulus(cur_cfg.m, cur_cfg.a));

  assert_period_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    per_len_q <= fb_modulus(cur_cfg.m, cur_cfg.a));

  assert_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse_o |=> !fb_pulse_o);

  assert_pre_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tc && wide_now) |-> pre_len_q == LEN_HI);

  assert_pre_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tc && !wide_now) |-> pre_len_q == LEN_LO);

  assert_half_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fb_half_o) |-> fb_pulse_o);

  assert_half_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_cfg.dbl |-> !fb_half_o);

  assert_err_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> cfg_err_o == !$past(fb_setting_ok(main_i, swallow_i)));

  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> fb_setting_ok(cur_cfg.m, cur_cfg.a));

  assert_no_midchange_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !start_q) |-> $stable(cur_cfg));

  assert_dbl_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && start_q && fb_half_o) |-> $stable(cur_cfg));
endmodule

bind fbdiv_top fbdiv_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .swallow_i  (swallow_i),
  .main_i     (main_i),
  .fb_pulse_o (fb_pulse_o),
  .fb_half_o  (fb_half_o),
  .cfg_err_o  (cfg_err_o),
  .start_q    (start_q),
  .base_tc    (base_tc),
  .pre_tc     (pre_tc),
  .wide_now   (wide_now),
  .cur_cfg    (cur_cfg)
);

// File: tb/fbdiv_top_tb_top.sv
module fbdiv_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] swallow_i = 2'd1;
  logic [6:0] main_i = 7'd9;
  logic       double_i = 1'b0;
  logic       fb_pulse_o;
  logic       fb_half_o;
  logic       cfg_err_o;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;   // rising edges since reset release

  always #2.5 clk = ~clk;

  fbdiv_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .swallow_i  (swallow_i),
    .main_i     (main_i),
    .double_i   (double_i),
    .fb_pulse_o (fb_pulse_o),
    .fb_half_o  (fb_half_o),
    .cfg_err_o  (cfg_err_o)
  );

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, ecnt);
    end
  endtask

  task automatic apply(input int m, input int a, input bit d);
    main_i    = 7'(m);
    swallow_i = 2'(a);
    double_i  = d;
  endtask

  task automatic do_reset(input int m, input int a, input bit d);
    @(negedge clk);
    rst_n = 1'b0;
    apply(m, a, d);
    repeat (3) @(negedge clk);
    check("R9 pulse in reset", int'(fb_pulse_o), 0);
    check("R9 half in reset", int'(fb_half_o), 0);
    check("R9 err in reset", int'(cfg_err_o), 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_until(input int edge_no);
    while (ecnt < edge_no) @(negedge clk);
  endtask

  // next pulse must be seen exactly after the given edge, none before
  task automatic expect_pulse(input string req, input int edge_no);
    do @(negedge clk); while (!fb_pulse_o && ecnt < edge_no + 4);
    check(req, ecnt, edge_no);
  endtask

  task automatic t_basic();
    do_reset(9, 1, 1'b0);
    expect_pulse("R2 first pulse N=37", 37);
    expect_pulse("R1 N=37 second", 74);
    expect_pulse("R1 N=37 third", 111);
    do_reset(112, 0, 1'b0);
    expect_pulse("R2 first pulse N=448", 448);
    expect_pulse("R1 N=448 second", 896);
    do_reset(50, 0, 1'b0);
    expect_pulse("R3 A=0 M=50", 200);
    expect_pulse("R3 A=0 M=50 second", 400);
    do_reset(50, 3, 1'b0);
    expect_pulse("R3 A=3 M=50", 203);
    expect_pulse("R3 A=3 M=50 second", 406);
    do_reset(10, 2, 1'b0);
    expect_pulse("R1 N=42", 42);
    expect_pulse("R1 N=42 second", 84);
  endtask

  task automatic t_double();
    int bad;
    do_reset(9, 1, 1'b1);
    bad = 0;
    for (int k = 0; k < 148; k++) begin
      @(negedge clk);
      if (int'(fb_half_o) != ((ecnt / 37) % 2)) bad++;
      if (int'(fb_pulse_o) != ((ecnt % 74) == 0 ? 1 : 0)) bad++;
    end
    check("R4 half wave and pulse over two doubled periods", bad, 0);
    do_reset(112, 0, 1'b1);
    expect_pulse("R4 doubled 896", 896);
    check("R4 half low after doubled pulse", int'(fb_half_o), 0);
    wait_until(896 + 448);
    check("R4 half high at midpoint", int'(fb_half_o), 1);
  endtask

  task automatic t_error();
    do_reset(9, 0, 1'b0);               // 36: out of range
    @(negedge clk);
    check("R5 err after N=36", int'(cfg_err_o), 1);
    expect_pulse("R6 default 37 held", 37);
    apply(20, 0, 1'b0);                 // start cycle: 80 accepted
    @(negedge clk);
    check("R5 err cleared for N=80", int'(cfg_err_o), 0);
    wait_until(40);
    apply(112, 1, 1'b0);                // 449
    @(negedge clk);
    check("R5 err for N=449", int'(cfg_err_o), 1);
    expect_pulse("R6 held 80 after 449", 117);
    apply(120, 0, 1'b0);                // 480, offered in start cycle
    @(negedge clk);
    check("R5 err for N=480", int'(cfg_err_o), 1);
    expect_pulse("R6 held 80 after 480", 197);
  endtask

  task automatic t_defer();
    do_reset(10, 0, 1'b0);              // 40
    wait_until(10);
    apply(25, 0, 1'b0);                 // 100, mid period
    expect_pulse("R7 mid change deferred", 40);
    expect_pulse("R7 mid change used next", 140);
    do_reset(10, 0, 1'b0);
    expect_pulse("R7 before boundary", 40);
    apply(25, 0, 1'b0);                 // first cycle of period
    expect_pulse("R7 change in start cycle taken", 140);
    do_reset(10, 0, 1'b0);
    expect_pulse("R7 before late change", 40);
    @(negedge clk);
    apply(25, 0, 1'b0);                 // one cycle after start
    expect_pulse("R7 late change deferred", 80);
    expect_pulse("R7 late change used next", 180);
  endtask

  task automatic t_dbl_defer();
    do_reset(9, 1, 1'b1);               // doubled 74
    wait_until(10);
    apply(9, 1, 1'b0);
    expect_pulse("R8 no pulse at midpoint", 74);
    expect_pulse("R8 normal mode after boundary", 111);
    check("R8 half idle after leaving doubling", int'(fb_half_o), 0);
    expect_pulse("R8 normal mode second", 148);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_basic();
    t_double();
    t_error();
    t_defer();
    t_dbl_defer();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule